// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block stands between a processor core and its external maskable interrupt request line. When a request arrives while interrupts are enabled, it runs a single-cycle acknowledge and latches whatever the interrupting device drives onto the data bus. It then works out where the core must go next. A 2-bit mode value selects one of four responses:

- Mode 0 passes the latched byte on as the first instruction of the service routine.
- Mode 1 jumps to one fixed entry address.
- Mode 2 combines a base register with an 8-bit vector to address a jump table.
- Mode 3 addresses the jump table with a full 16-bit vector.

For the table modes the block makes the two byte reads itself, low byte first.

An undefined-opcode trap input is served ahead of any pending request and sends the core to a dedicated handler. The result reaches the core as a one-cycle completion pulse. The pulse carries a 16-bit target and flags that mark an instruction byte or a trap. The core sets the mode, the table base and the enable flag through a simple write strobe.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, irq_ack, mem_rd, done, done_is_instr and done_is_trap are all 0, the mode is 0 and the enable flag is cleared, and a pending request is not acknowledged until the enable flag is written to 1.
- R2: While the enable flag is 0, irq_req produces no acknowledge and no completion.
- R3: A request that is sampled at a clock edge while the flag is enabled raises irq_ack for exactly one cycle, starting the next cycle. Accepting the request clears the flag, so a request held high gets no second acknowledge.
- R4: In mode 0 (cfg_mode=0), done pulses the cycle after irq_ack with done_target = {8'h00, bus_data[7:0]} sampled during irq_ack, and with done_is_instr=1.
- R5: In mode 1 (cfg_mode=1), done pulses the cycle after irq_ack with done_target = 16'h0038 and done_is_instr=0, and mem_rd is never raised.
- R6: In mode 2 (cfg_mode=2), the table address T is {base, bus_data[7:0]} with bit 0 cleared. Reads of T and then T+1 go out on the two cycles after irq_ack. Read data returns one cycle after each read, and done pulses two cycles after the second read with done_target = {byte(T+1), byte(T)}.
- R7: In mode 3 (cfg_mode=3), the table address is bus_data[15:0] with bit 0 cleared, and the read order and timing are those of R6.
- R8: A trap_req sampled while no sequence is running gives done with done_target = 16'h0000 and done_is_trap=1 the next cycle. It wins over a request sampled at the same edge, and that request is served afterwards.
- R9: The mode and base used by a sequence are those held when its request was accepted. Writes made during the sequence affect only later requests.
- R10: Asserting rst_n aborts a running sequence: no completion follows it.
- R11: done_is_instr and done_is_trap are never both 1. Every completion matches exactly one accepted request or trap, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_req | input | 1 | External maskable interrupt request, level |
| irq_ack | output | 1 | Acknowledge, one cycle; bus_data is latched in this cycle |
| bus_data | input | 16 | Data the device drives during acknowledge |
| trap_req | input | 1 | Undefined-opcode trap from the core |
| cfg_we | input | 1 | Write strobe for mode, base and enable |
| cfg_mode | input | 2 | Response mode to write |
| cfg_base | input | 8 | Jump-table base (high byte) to write |
| cfg_ie | input | 1 | Interrupt-enable value to write |
| mem_rd | output | 1 | Memory byte read strobe |
| mem_addr | output | 16 | Memory byte address |
| mem_rdata | input | 8 | Read data, valid one cycle after mem_rd |
| done | output | 1 | Completion pulse |
| done_target | output | 16 | Entry address, or the instruction byte in mode 0 |
| done_is_instr | output | 1 | done_target holds an instruction byte |
| done_is_trap | output | 1 | Completion is the undefined-opcode trap |

## Verification
The assertions check on every cycle that the acknowledge lasts a single cycle and follows a request. They check that table reads come as an even/odd address pair and never overlap the acknowledge, that a trap completion carries the zero target, that the two flags never combine, and that a non-instruction completion right after an acknowledge carries the fixed entry. Other properties need a whole scenario and only the bench's scoreboard can show them:
- the table contents assembled low byte first;
- the correct base and vector bits;
- the mode and base snapshot taken at acceptance;
- the enable flag being cleared;
- the ordering of a trap against a request sampled at the same edge;
- the lost completion after a reset in mid-sequence.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ACK  = 3'd1,
    ST_RDL  = 3'd2,
    ST_RDH  = 3'd3,
    ST_RDW  = 3'd4
  } seq_st_e;

  typedef enum logic [1:0] {
    IM_INSTR   = 2'd0,
    IM_FIXED   = 2'd1,
    IM_TABLE8  = 2'd2,
    IM_TABLE16 = 2'd3
  } irq_mode_e;

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_seq_pkg::*;
#(
  parameter int BASE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_mode,
  input  logic [BASE_W-1:0] wr_base,
  input  logic              wr_ie,
  input  logic              accept,
  output irq_mode_e         mode_q,
  output logic [BASE_W-1:0] base_q,
  output logic              ie_q
);

  irq_mode_e         mode_d;
  logic [BASE_W-1:0] base_d;
  logic              ie_d;

  always_comb begin
    mode_d = mode_q;
    base_d = base_q;
    ie_d   = ie_q;
    if (wr_en) begin
      mode_d = irq_mode_e'(wr_mode);
      base_d = wr_base;
      ie_d   = wr_ie;
    end
    // acceptance wins over a simultaneous write of the enable flag
    if (accept) ie_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= IM_INSTR;
      base_q <= '0;
      ie_q   <= 1'b0;
    end else begin
      if (wr_en) begin
        mode_q <= mode_d;
        base_q <= base_d;
      end
      if (wr_en || accept) ie_q <= ie_d;
    end
  end

endmodule

// File: rtl/irq_tbl_addr.sv
module irq_tbl_addr
  import irq_seq_pkg::*;
#(
  parameter int AW     = 16,
  parameter int VW     = 16,
  parameter int BASE_W = 8
) (
  input  irq_mode_e         mode,
  input  logic [BASE_W-1:0] base,
  input  logic [VW-1:0]     vec,
  output logic [AW-1:0]     tbl_addr
);

  localparam int             LOW_W     = AW - BASE_W;
  localparam logic [AW-1:0]  EVEN_MASK = ~AW'(1);

  logic [AW-1:0] wide_vec;
  logic [AW-1:0] raw;

  generate
    if (VW >= AW) begin : g_trunc
      assign wide_vec = vec[AW-1:0];
    end else begin : g_ext
      assign wide_vec = {{(AW-VW){1'b0}}, vec};
    end
  endgenerate

  always_comb begin
    if (mode == IM_TABLE16) raw = wide_vec;
    else                    raw = {base, wide_vec[LOW_W-1:0]};
    tbl_addr = raw & EVEN_MASK;
  end

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
#(
  parameter int            AW          = 16,
  parameter int            BASE_W      = 8,
  parameter logic [AW-1:0] FIXED_ENTRY = 16'h0038,
  parameter logic [AW-1:0] TRAP_ENTRY  = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req,
  input  logic              ie,
  input  logic              trap_req,
  input  irq_mode_e         cfg_mode,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic [7:0]        bus_byte,
  input  logic [AW-1:0]     tbl_addr,
  input  logic [7:0]        mem_rdata,
  output irq_mode_e         snap_mode,
  output logic [BASE_W-1:0] snap_base,
  output logic              accept,
  output logic              ack,
  output logic              mem_rd,
  output logic [AW-1:0]     mem_addr,
  output logic              done,
  output logic [AW-1:0]     done_target,
  output logic              done_is_instr,
  output logic              done_is_trap
);

  seq_st_e       st_q, st_d;
  logic [AW-1:0] tbl_q;
  logic [7:0]    lo_q;
  logic          done_q, instr_q, trap_q;
  logic [AW-1:0] tgt_q;

  logic          fin, fin_instr, fin_trap;
  logic [AW-1:0] fin_tgt;

  always_comb begin
    st_d      = st_q;
    accept    = 1'b0;
    fin       = 1'b0;
    fin_instr = 1'b0;
    fin_trap  = 1'b0;
    fin_tgt   = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (trap_req) begin
          fin      = 1'b1;
          fin_trap = 1'b1;
          fin_tgt  = TRAP_ENTRY;
        end else if (irq_req && ie) begin
          accept = 1'b1;
          st_d   = ST_ACK;
        end
      end
      ST_ACK: begin
        unique case (snap_mode)
          IM_INSTR: begin
            fin       = 1'b1;
            fin_instr = 1'b1;
            fin_tgt   = AW'(bus_byte);
            st_d      = ST_IDLE;
          end
          IM_FIXED: begin
            fin     = 1'b1;
            fin_tgt = FIXED_ENTRY;
            st_d    = ST_IDLE;
          end
          default: st_d = ST_RDL;
        endcase
      end
      ST_RDL: st_d = ST_RDH;
      ST_RDH: st_d = ST_RDW;
      ST_RDW: begin
        fin     = 1'b1;
        fin_tgt = AW'({mem_rdata, lo_q});
        st_d    = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      snap_mode <= IM_INSTR;
      snap_base <= '0;
      tbl_q     <= '0;
      lo_q      <= '0;
      done_q    <= 1'b0;
      tgt_q     <= '0;
      instr_q   <= 1'b0;
      trap_q    <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= fin;
      if (accept) begin
        snap_mode <= cfg_mode;
        snap_base <= cfg_base;
      end
      if (st_q == ST_ACK) tbl_q <= tbl_addr;
      if (st_q == ST_RDH) lo_q  <= mem_rdata;
      if (fin) begin
        tgt_q   <= fin_tgt;
        instr_q <= fin_instr;
        trap_q  <= fin_trap;
      end
    end
  end

  assign ack           = (st_q == ST_ACK);
  assign mem_rd        = (st_q == ST_RDL) || (st_q == ST_RDH);
  assign mem_addr      = (st_q == ST_RDH) ? (tbl_q | AW'(1)) :
                         (st_q == ST_RDL) ? tbl_q : '0;
  assign done          = done_q;
  assign done_target   = tgt_q;
  assign done_is_instr = done_q & instr_q;
  assign done_is_trap  = done_q & trap_q;

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int            AW          = 16,
  parameter int            VW          = 16,
  parameter int            BASE_W      = 8,
  parameter logic [AW-1:0] FIXED_ENTRY = 16'h0038,
  parameter logic [AW-1:0] TRAP_ENTRY  = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req,
  output logic              irq_ack,
  input  logic [VW-1:0]     bus_data,
  input  logic              trap_req,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_mode,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic              cfg_ie,
  output logic              mem_rd,
  output logic [AW-1:0]     mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              done,
  output logic [AW-1:0]     done_target,
  output logic              done_is_instr,
  output logic              done_is_trap
);

  logic [1:0]        rst_ff;
  logic              rst_int_n;
  irq_mode_e         mode_q, snap_mode;
  logic [BASE_W-1:0] base_q, snap_base;
  logic              ie_q, accept;
  logic [AW-1:0]     tbl_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_int_n = rst_ff[1];

  irq_cfg_regs #(.BASE_W(BASE_W)) u_cfg (
    .clk(clk), .rst_n(rst_int_n), .wr_en(cfg_we), .wr_mode(cfg_mode),
    .wr_base(cfg_base), .wr_ie(cfg_ie), .accept(accept),
    .mode_q(mode_q), .base_q(base_q), .ie_q(ie_q)
  );

  irq_tbl_addr #(.AW(AW), .VW(VW), .BASE_W(BASE_W)) u_addr (
    .mode(snap_mode), .base(snap_base), .vec(bus_data), .tbl_addr(tbl_addr)
  );

  irq_seq_fsm #(
    .AW(AW), .BASE_W(BASE_W), .FIXED_ENTRY(FIXED_ENTRY), .TRAP_ENTRY(TRAP_ENTRY)
  ) u_fsm (
    .clk(clk), .rst_n(rst_int_n), .irq_req(irq_req), .ie(ie_q),
    .trap_req(trap_req), .cfg_mode(mode_q), .cfg_base(base_q),
    .bus_byte(bus_data[7:0]), .tbl_addr(tbl_addr), .mem_rdata(mem_rdata),
    .snap_mode(snap_mode), .snap_base(snap_base), .accept(accept),
    .ack(irq_ack), .mem_rd(mem_rd), .mem_addr(mem_addr), .done(done),
    .done_target(done_target), .done_is_instr(done_is_instr),
    .done_is_trap(done_is_trap)
  );

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int            AW          = 16,
  parameter logic [AW-1:0] FIXED_ENTRY = 16'h0038
) (
  input logic          clk,
  input logic          rst_int_n,
  input logic          irq_req,
  input logic          irq_ack,
  input logic          mem_rd,
  input logic [AW-1:0] mem_addr,
  input logic          done,
  input logic [AW-1:0] done_target,
  input logic          done_is_instr,
  input logic          done_is_trap
);

  a_r3_ack_single: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_ack |=> !irq_ack);

  a_r3_ack_after_req: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_ack |-> $past(irq_req));

  a_r6_read_even_first: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(mem_rd) |-> (mem_addr[0] == 1'b0));

  a_r6_read_pair: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(mem_rd) |=> (mem_rd && mem_addr == $past(mem_addr) + AW'(1)));

  a_r6_read_two_only: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mem_rd && $past(mem_rd)) |=> !mem_rd);

  a_r6_no_read_during_ack: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_rd |-> !irq_ack);

  a_r4_instr_after_ack: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && done_is_instr) |-> $past(irq_ack));

  a_r5_fixed_target: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && !done_is_instr && !done_is_trap && $past(irq_ack)) |-> (done_target == FIXED_ENTRY));

  a_r8_trap_target: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && done_is_trap) |-> (done_target == '0));

  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(done_is_instr && done_is_trap));

endmodule

bind irq_entry_seq irq_entry_seq_chk #(.AW(AW), .FIXED_ENTRY(FIXED_ENTRY)) u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .irq_req(irq_req), .irq_ack(irq_ack),
  .mem_rd(mem_rd), .mem_addr(mem_addr), .done(done), .done_target(done_target),
  .done_is_instr(done_is_instr), .done_is_trap(done_is_trap)
);

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;

  logic        clk = 1'b0;
  logic        rst_n, irq_req, irq_ack, trap_req, cfg_we, cfg_ie;
  logic [15:0] bus_data, mem_addr, done_target;
  logic [1:0]  cfg_mode;
  logic [7:0]  cfg_base, mem_rdata;
  logic        mem_rd, done, done_is_instr, done_is_trap;

  always #5 clk = ~clk;

  irq_entry_seq u0 (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_ack(irq_ack),
    .bus_data(bus_data), .trap_req(trap_req), .cfg_we(cfg_we),
    .cfg_mode(cfg_mode), .cfg_base(cfg_base), .cfg_ie(cfg_ie),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .done(done), .done_target(done_target), .done_is_instr(done_is_instr),
    .done_is_trap(done_is_trap)
  );

  typedef struct packed {
    logic [15:0] tgt;
    logic        instr;
    logic        trap;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0, errors = 0, ack_cnt = 0, rd_cnt = 0;

  function automatic logic [7:0] fmem(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  // memory model: one cycle read latency
  always @(posedge clk) if (mem_rd) mem_rdata <= fmem(mem_addr);

  // monitor / scoreboard
  always @(negedge clk) begin
    if (irq_ack) ack_cnt++;
    if (mem_rd)  rd_cnt++;
    if (done) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected completion: actual target=%h instr=%b trap=%b expected none",
                 done_target, done_is_instr, done_is_trap);
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (done_target != e.tgt || done_is_instr != e.instr || done_is_trap != e.trap) begin
          errors++;
          $display("FAIL %s completion: actual target=%h instr=%b trap=%b expected target=%h instr=%b trap=%b",
                   t, done_target, done_is_instr, done_is_trap, e.tgt, e.instr, e.trap);
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_done(input string req, input logic [15:0] tgt, input logic instr, input logic trap);
    exp_t e;
    e.tgt = tgt; e.instr = instr; e.trap = trap;
    exp_q.push_back(e);
    tag_q.push_back(req);
  endtask

  task automatic cfg(input logic [1:0] m, input logic [7:0] b, input logic ie);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_mode = m; cfg_base = b; cfg_ie = ie;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  // raise a request and wait until it is acknowledged; optionally keep it high
  task automatic raise_irq(input logic [15:0] d, input bit hold);
    @(posedge clk); #1;
    irq_req = 1'b1; bus_data = d;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (irq_ack) break;
    end
    @(posedge clk); #1;
    if (!hold) irq_req = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int a0;
    int r0;
    logic [15:0] t;
    rst_n = 1'b0; irq_req = 1'b0; trap_req = 1'b0; cfg_we = 1'b0;
    cfg_mode = 2'd0; cfg_base = 8'h00; cfg_ie = 1'b0; bus_data = 16'h0000;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    settle(4);

    // R1: reset state
    @(negedge clk);
    chk("R1 outputs after reset", {irq_ack, mem_rd, done, done_is_instr, done_is_trap}, 0);

    // R1/R2: enable cleared by reset, request ignored
    a0 = ack_cnt;
    @(posedge clk); #1 irq_req = 1'b1; bus_data = 16'h00AA;
    settle(6);
    irq_req = 1'b0;
    chk("R2 no ack while disabled", ack_cnt - a0, 0);

    // R4 mode 0, and R3 held request gets one ack only
    cfg(2'd0, 8'h00, 1'b1);
    a0 = ack_cnt;
    expect_done("R4", 16'h00C7, 1'b1, 1'b0);
    raise_irq(16'h03C7, 1'b1);
    settle(6);
    irq_req = 1'b0;
    chk("R3 single ack for held request", ack_cnt - a0, 1);

    // R5 mode 1
    cfg(2'd1, 8'h00, 1'b1);
    r0 = rd_cnt;
    expect_done("R5", 16'h0038, 1'b0, 1'b0);
    raise_irq(16'hFFFF, 1'b0);
    settle(6);
    chk("R5 no memory reads", rd_cnt - r0, 0);

    // R6 mode 2
    cfg(2'd2, 8'h12, 1'b1);
    r0 = rd_cnt;
    expect_done("R6", {fmem(16'h1235), fmem(16'h1234)}, 1'b0, 1'b0);
    raise_irq(16'h9935, 1'b0);
    settle(6);
    chk("R6 two memory reads", rd_cnt - r0, 2);

    // R7 mode 3
    cfg(2'd3, 8'h12, 1'b1);
    expect_done("R7", {fmem(16'hABCD), fmem(16'hABCC)}, 1'b0, 1'b0);
    raise_irq(16'hABCD, 1'b0);
    settle(6);

    // R8 trap beats a simultaneous request, which is served after
    cfg(2'd3, 8'h00, 1'b1);
    expect_done("R8 trap", 16'h0000, 1'b0, 1'b1);
    expect_done("R8 request after trap", {fmem(16'h4001), fmem(16'h4000)}, 1'b0, 1'b0);
    @(posedge clk); #1;
    trap_req = 1'b1; irq_req = 1'b1; bus_data = 16'h4001;
    @(posedge clk); #1;
    trap_req = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (irq_ack) break;
    end
    @(posedge clk); #1 irq_req = 1'b0;
    settle(6);

    // R8 trap with interrupts disabled
    expect_done("R8 trap disabled", 16'h0000, 1'b0, 1'b1);
    @(posedge clk); #1 trap_req = 1'b1;
    @(posedge clk); #1 trap_req = 1'b0;
    settle(3);

    // R9 mid-sequence writes do not disturb running sequence
    cfg(2'd2, 8'h12, 1'b1);
    t = {fmem(16'h1257), fmem(16'h1256)};
    expect_done("R9 snapshot", t, 1'b0, 1'b0);
    raise_irq(16'h0056, 1'b0);
    cfg_we = 1'b1; cfg_mode = 2'd1; cfg_base = 8'h77; cfg_ie = 1'b1;
    @(posedge clk); #1 cfg_we = 1'b0;
    settle(6);
    expect_done("R9 new mode", 16'h0038, 1'b0, 1'b0);
    raise_irq(16'h0056, 1'b0);
    settle(6);

    // R10 reset aborts a table sequence
    cfg(2'd2, 8'h30, 1'b1);
    raise_irq(16'h0010, 1'b0);
    rst_n = 1'b0;
    settle(3);
    rst_n = 1'b1;
    settle(6);
    chk("R10 no completion after abort", exp_q.size(), 0);
    a0 = ack_cnt;
    @(posedge clk); #1 irq_req = 1'b1;
    settle(6);
    irq_req = 1'b0;
    chk("R1 enable cleared by reset", ack_cnt - a0, 0);

    settle(4);
    chk("R11 scoreboard drained", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule